// File: doc/BRIEF.md
# Microwire Serial Master

This block is a register-driven serial master for Microwire-style peripherals. A host reaches five 16-bit registers over a simple read/write port: a data word, a control/status word, two chip-select configuration words and a global clock word. To run a transfer, the host loads the data word and then writes a control word. That control word sets a write bit count, a read bit count and the start bit. The block sends the write bits MSB first and then collects the read bits from the same serial clock train.

The chip selects are not part of a transfer. Each one is driven by a control write that does not carry the start bit. That write names a select by index and either asserts it or releases it. Each select has its own sampling edge, launch edge, active level and serial clock divider. A global prescaler feeds all of these dividers. The host polls a busy flag and a read-ready flag to follow progress.

The host port has no back-pressure. A register access is taken in the cycle it is presented, and read data is valid in that same cycle. A control write or data write made while busy is set is dropped. The serial pins carry no handshake of their own: the serial clock paces both directions.

Top module: `mw_master`

## Requirements
- R1: After reset, busy and read-ready read 0, the serial clock is low, and every chip-select pin sits at its inactive level, which is 1 while all configuration is zero.
- R2: The configuration registers sit at byte offsets 0x04, 0x06 and 0x08. The chip-select words keep bits 11:0 and the global word keeps bits 2:0. Every other bit reads back as 0.
- R3: The write phase sends bits 15 down to 16-N of the data word (offset 0x00), MSB first, where N is the write count in control bits 9:5.
- R4: The read phase follows the write phase and takes the number of bits given in control bits 4:0. At the end, the received bits sit right-aligned in the data word, the first bit received is the most significant, and read-ready (control bit 15) is set.
- R5: A read of the data word with the clear strobe asserted clears read-ready.
- R6: A control write with start (bit 13) clear drives the chip select indexed by bits 11:10 to its active level when bit 12 is 1, and to its inactive level when bit 12 is 0. Busy (bit 14) stays set until a prescaler tick applies the change, and a select changes only on such a tick.
- R7: Each select has a 6-bit field. Indices 0 and 1 are in the word at 0x04 and indices 2 and 3 are in the word at 0x06; odd indices use bits 11:6 and even indices use bits 5:0. In a field, bit 0 is the sampling edge, bit 1 is the launch edge (1 = falling, 0 = rising for both) and bit 2 is the active level.
- R8: Field bits 4:3 pick the serial clock divider: 0 gives 2, 1 gives 4, and 2 or 3 gives 8. The serial clock period is this divider times the prescaler, counted in system clocks.
- R9: Global bits 2:1 pick the prescaler: 0 gives 2, 1 gives 4, 2 gives 7 and 3 gives 10.
- R10: While the global enable (bit 0) is low, the serial clock does not move and busy holds. Pending work resumes once the enable is set.
- R11: A start with both counts zero completes at once. Busy is clear in the next cycle and the serial clock does not toggle.
- R12: A count above 16 is treated as 16.
- R13: The serial clock idles low and toggles only while busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe; on the data word it clears read-ready |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the peripheral |
| sdi | input | 1 | Serial data from the peripheral |
| cs_o | output | 4 | Chip-select pins, each at its configured level |

## Verification
The bound checker watches several rules on every clock. The serial clock stays low while idle and holds still while the global enable is off. A chip select moves only on a prescaler tick. A start with zero counts leaves busy clear. Read-ready sets as soon as a read phase ends and clears on a strobed data read. Some behaviour cannot be seen from single-cycle relations and is left to the bench scenarios: bit order and alignment of both phases, the choice of edges per select, clamping of the counts, and the serial period produced by each divider and prescaler setting. The bench finds these by watching the serial pins edge by edge and reading back the data word.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = 5;
  localparam int unsigned NSEL   = 4;
  localparam int unsigned IDX_W  = $clog2(NSEL);
  localparam int unsigned BIT_W  = CNT_W + 1;
  localparam int unsigned PCNT_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_SHIFT} mw_state_e;

  typedef struct packed {
    logic [1:0] div;
    logic       lvl;
    logic       launch_fall;
    logic       samp_fall;
  } sel_cfg_t;

  function automatic logic [PCNT_W-1:0] presc_last(input logic [1:0] code);
    case (code)
      2'd0:    return PCNT_W'(1);
      2'd1:    return PCNT_W'(3);
      2'd2:    return PCNT_W'(6);
      default: return PCNT_W'(9);
    endcase
  endfunction

  function automatic logic [1:0] half_last(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] n);
    return (n > CNT_W'(WORD_W)) ? CNT_W'(WORD_W) : n;
  endfunction

  function automatic sel_cfg_t pick_cfg(input logic [11:0] lo_w, input logic [11:0] hi_w,
                                        input logic [IDX_W-1:0] idx);
    logic [11:0] w;
    w = idx[1] ? hi_w : lo_w;
    return idx[0] ? sel_cfg_t'(w[10:6]) : sel_cfg_t'(w[4:0]);
  endfunction
endpackage

// File: rtl/mw_prescaler.sv
module mw_prescaler
  import mw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PCNT_W-1:0] cnt;
  logic [PCNT_W-1:0] lim;

  assign lim  = presc_last(code);
  assign tick = en && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mw_regs.sv
module mw_regs
  import mw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [3:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              busy,
  input  logic              rx_done,
  input  logic [WORD_W-1:0] rx_word,
  output logic [11:0]       sel_lo,
  output logic [11:0]       sel_hi,
  output logic [2:0]        glob,
  output logic              go_shift,
  output logic              go_sel,
  output logic [WORD_W-1:0] tx_word,
  output logic              rdy
);
  logic [WORD_W-1:0] data_q;
  logic [12:0]       ctl_q;
  logic              ctl_acc;

  assign ctl_acc  = wr && (addr == 4'h2) && !busy;
  assign go_shift = ctl_acc && wdata[13];
  assign go_sel   = ctl_acc && !wdata[13];
  assign tx_word  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
      sel_lo <= '0;
      sel_hi <= '0;
      glob   <= '0;
      rdy    <= 1'b0;
    end else begin
      if (wr && (addr == 4'h0) && !busy) data_q <= wdata;
      if (ctl_acc)                        ctl_q  <= wdata[12:0];
      if (wr && (addr == 4'h4))           sel_lo <= wdata[11:0];
      if (wr && (addr == 4'h6))           sel_hi <= wdata[11:0];
      if (wr && (addr == 4'h8))           glob   <= wdata[2:0];
      if (rx_done) begin
        data_q <= rx_word;
        rdy    <= 1'b1;
      end else if (rd && (addr == 4'h0)) begin
        rdy    <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      4'h0:    rdata = data_q;
      4'h2:    rdata = {rdy, busy, 1'b0, ctl_q};
      4'h4:    rdata = {4'h0, sel_lo};
      4'h6:    rdata = {4'h0, sel_hi};
      4'h8:    rdata = {13'h0, glob};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
  import mw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go_shift,
  input  logic              go_sel,
  input  logic [CNT_W-1:0]  wcnt,
  input  logic [CNT_W-1:0]  rcnt,
  input  logic [IDX_W-1:0]  idx,
  input  logic              sel_val,
  input  logic [WORD_W-1:0] tx_word,
  input  sel_cfg_t          cfg,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic [NSEL-1:0]   cs_act,
  output logic              busy,
  output logic              rx_done,
  output logic [WORD_W-1:0] rx_word
);
  mw_state_e         st;
  sel_cfg_t          cfg_q;
  logic [WORD_W-1:0] sh, rx, rx_next;
  logic [CNT_W-1:0]  nw;
  logic [BIT_W-1:0]  nt, bi, tot;
  logic [IDX_W-1:0]  pidx;
  logic              pval, ph, in_rd;
  logic [1:0]        hc, hlast;
  logic [CNT_W-1:0]  wc, rc;

  assign wc      = clamp_cnt(wcnt);
  assign rc      = clamp_cnt(rcnt);
  assign tot     = {1'b0, wc} + {1'b0, rc};
  assign rx_next = {rx[WORD_W-2:0], sdi};
  assign in_rd   = bi >= {1'b0, nw};
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cfg_q   <= '0;
      sh      <= '0;
      rx      <= '0;
      nw      <= '0;
      nt      <= '0;
      bi      <= '0;
      ph      <= 1'b0;
      hc      <= '0;
      hlast   <= '0;
      pidx    <= '0;
      pval    <= 1'b0;
      sclk    <= 1'b0;
      sdo     <= 1'b0;
      cs_act  <= '0;
      rx_done <= 1'b0;
      rx_word <= '0;
    end else begin
      rx_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go_shift) begin
            if (tot != '0) begin
              st    <= ST_SHIFT;
              cfg_q <= cfg;
              nw    <= wc;
              nt    <= tot;
              bi    <= '0;
              ph    <= 1'b0;
              hc    <= '0;
              hlast <= half_last(cfg.div);
              rx    <= '0;
              if (cfg.launch_fall && (wc != '0)) begin
                sdo <= tx_word[WORD_W-1];
                sh  <= {tx_word[WORD_W-2:0], 1'b0};
              end else begin
                sh  <= tx_word;
              end
            end
          end else if (go_sel) begin
            st   <= ST_SEL;
            pidx <= idx;
            pval <= sel_val;
          end
        end
        ST_SEL: begin
          if (tick) begin
            cs_act[pidx] <= pval;
            st           <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (hc != hlast) begin
              hc <= hc + 1'b1;
            end else begin
              hc <= '0;
              if (!ph) begin
                ph   <= 1'b1;
                sclk <= 1'b1;
                if (!in_rd && !cfg_q.launch_fall) begin
                  sdo <= sh[WORD_W-1];
                  sh  <= {sh[WORD_W-2:0], 1'b0};
                end
                if (in_rd && !cfg_q.samp_fall) rx <= rx_next;
              end else begin
                ph   <= 1'b0;
                sclk <= 1'b0;
                if (in_rd && cfg_q.samp_fall) rx <= rx_next;
                if (bi == nt - 1'b1) begin
                  st <= ST_IDLE;
                  if (nt != {1'b0, nw}) begin
                    rx_done <= 1'b1;
                    rx_word <= (in_rd && cfg_q.samp_fall) ? rx_next : rx;
                  end
                end else begin
                  bi <= bi + 1'b1;
                  if (cfg_q.launch_fall && ((bi + 1'b1) < {1'b0, nw})) begin
                    sdo <= sh[WORD_W-1];
                    sh  <= {sh[WORD_W-2:0], 1'b0};
                  end
                end
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic [NSEL-1:0]   cs_o
);
  logic [11:0]       sel_lo, sel_hi;
  logic [2:0]        glob;
  logic              go_shift, go_sel, busy, rx_done, rdy, tick;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [NSEL-1:0]   cs_act;
  sel_cfg_t          cmd_cfg;

  mw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .rx_done(rx_done),
    .rx_word(rx_word), .sel_lo(sel_lo), .sel_hi(sel_hi), .glob(glob),
    .go_shift(go_shift), .go_sel(go_sel), .tx_word(tx_word), .rdy(rdy)
  );

  mw_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .en(glob[0]), .code(glob[2:1]), .tick(tick)
  );

  assign cmd_cfg = pick_cfg(sel_lo, sel_hi, bus_wdata[11:10]);

  mw_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go_shift(go_shift), .go_sel(go_sel),
    .wcnt(bus_wdata[9:5]), .rcnt(bus_wdata[4:0]), .idx(bus_wdata[11:10]),
    .sel_val(bus_wdata[12]), .tx_word(tx_word), .cfg(cmd_cfg), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .cs_act(cs_act), .busy(busy), .rx_done(rx_done),
    .rx_word(rx_word)
  );

  for (genvar g = 0; g < NSEL; g++) begin : g_cs
    sel_cfg_t c;
    assign c       = pick_cfg(sel_lo, sel_hi, IDX_W'(g));
    assign cs_o[g] = cs_act[g] ? c.lvl : ~c.lvl;
  end
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk
  import mw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            sclk,
  input logic            tick,
  input logic            clk_en,
  input logic [NSEL-1:0] cs_act,
  input logic            rd_data,
  input logic            rx_done,
  input logic            rdy,
  input logic            zstart
);
  // R13
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R10
  frozen_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(sclk));
  // R6
  sel_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cs_act));
  // R11
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zstart |=> !busy);
  // R4
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rdy);
  // R5
  rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !rdy);
endmodule

bind mw_master mw_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .tick(tick),
  .clk_en(glob[0]), .cs_act(cs_act),
  .rd_data(bus_rd && (bus_addr == 4'h0)), .rx_done(rx_done), .rdy(rdy),
  .zstart(bus_wr && (bus_addr == 4'h2) && bus_wdata[13] && (bus_wdata[9:0] == 10'd0) && !busy)
);

// File: tb/mw_master_tb.sv
`timescale 1ns/1ps
module mw_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, sdi = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        sclk, sdo;
  logic [3:0]  cs_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [11:0] m_lo = 12'h0, m_hi = 12'h0;
  logic [3:0]  m_act = 4'h0;
  bit          pend = 1'b0, done_flag = 1'b0;

  // monitor state for the serial pins
  logic q_r[$], q_f[$];
  int   t_rise[$];
  int   rise_n = 0, fall_n = 0, cw = 0, cr = 0;
  logic [15:0] cpat = 16'h0;
  bit   csf = 1'b0;

  always #2.5 clk = ~clk;

  mw_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .cs_o(cs_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_cs(input int i);
    logic lvl;
    lvl = (i < 2) ? ((i % 2) != 0 ? m_lo[8] : m_lo[2]) : ((i % 2) != 0 ? m_hi[8] : m_hi[2]);
    return m_act[i] ? lvl : ~lvl;
  endfunction

  function automatic logic rbit(input int k);
    if (k < cw || k >= cw + cr) return 1'b0;
    return cpat[cr - 1 - (k - cw)];
  endfunction

  // behavioural model of the chip-select pins, compared every clock
  always @(posedge clk) begin
    cyc++;
    #1;
    if (rst_n && !pend && !done_flag) begin
      for (int i = 0; i < 4; i++) chk(cs_o[i] === exp_cs(i), "R6 cs pin", int'(cs_o[i]), int'(exp_cs(i)));
    end
  end

  always @(posedge sclk) begin
    q_r.push_back(sdo);
    t_rise.push_back(cyc);
    if (!csf) sdi = rbit(rise_n + 1);
    rise_n++;
  end

  always @(negedge sclk) begin
    q_f.push_back(sdo);
    if (csf) sdi = rbit(fall_n + 1);
    fall_n++;
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 4'h4) m_lo = d[11:0];
    if (a == 4'h6) m_hi = d[11:0];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input bit clr, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = clr;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] v;
    int n;
    n = 0;
    do begin
      rd(4'h2, 1'b0, v);
      n++;
    end while (v[14] && n < 3000);
    chk(!v[14], req, int'(v[14]), 0);
  endtask

  task automatic sel_cmd(input int idx, input bit val, input string req);
    pend = 1'b1;
    wr(4'h2, 16'((int'(val) << 12) | (idx << 10)));
    wait_idle(req);
    m_act[idx] = val;
    pend = 1'b0;
  endtask

  task automatic arm(input int w, input int r, input logic [15:0] pat, input bit sf);
    cw = (w > 16) ? 16 : w;
    cr = (r > 16) ? 16 : r;
    cpat = pat; csf = sf;
    q_r.delete(); q_f.delete(); t_rise.delete();
    rise_n = 0; fall_n = 0;
    sdi = rbit(0);
  endtask

  task automatic xfer(input int idx, input int w, input int r, input logic [15:0] tx,
                      input logic [15:0] pat, input bit lf, input bit sf, input string req);
    logic [15:0] got, wmask, rmask, v;
    arm(w, r, pat, sf);
    wr(4'h0, tx);
    wr(4'h2, 16'((1 << 13) | (idx << 10) | ((w & 31) << 5) | (r & 31)));
    wait_idle(req);
    chk(rise_n == cw + cr, {req, " edge count"}, rise_n, cw + cr);
    chk(sclk == 1'b0, "R13 idle low", int'(sclk), 0);
    if (cw > 0) begin
      got = 16'h0;
      for (int k = 0; k < cw; k++) begin
        if (lf) got[15-k] = (k < q_r.size()) ? q_r[k] : 1'b0;
        else    got[15-k] = (k < q_f.size()) ? q_f[k] : 1'b0;
      end
      wmask = 16'hFFFF << (16 - cw);
      chk(got == (tx & wmask), {req, " write bits"}, int'(got), int'(tx & wmask));
    end
    if (cr > 0) begin
      rmask = 16'((17'h1 << cr) - 17'h1);
      rd(4'h0, 1'b0, v);
      chk(v == (pat & rmask), {req, " read word"}, int'(v), int'(pat & rmask));
      rd(4'h2, 1'b0, v);
      chk(v[15] == 1'b1, "R4 ready set", int'(v[15]), 1);
      rd(4'h0, 1'b1, v);
      rd(4'h2, 1'b0, v);
      chk(v[15] == 1'b0, "R5 ready cleared", int'(v[15]), 0);
    end
  endtask

  task automatic finish_up();
    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(4'h2, 1'b0, v);
    chk(v[15:14] == 2'b00, "R1 flags", int'(v[15:14]), 0);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(cs_o == 4'hF, "R1 cs pins", int'(cs_o), 15);
    // R2 register map
    wr(4'h4, 16'hFFFF);
    rd(4'h4, 1'b0, v);
    chk(v == 16'h0FFF, "R2 sel word lo", int'(v), 16'h0FFF);
    wr(4'h8, 16'hFFFF);
    rd(4'h8, 1'b0, v);
    chk(v == 16'h0007, "R2 global word", int'(v), 7);
    wr(4'h4, 16'h0000);
    wr(4'h8, 16'h0001);
    // R6 chip select assert / release, active-high select on index 2
    sel_cmd(0, 1'b1, "R6 busy after assert");
    wr(4'h6, 16'h0004);
    sel_cmd(2, 1'b1, "R6 busy after assert hi");
    chk(cs_o[2] == 1'b1, "R6 active high", int'(cs_o[2]), 1);
    // R3 write only, rising launch
    xfer(0, 8, 0, 16'hA500, 16'h0, 1'b0, 1'b0, "R3");
    // R4 read only, rising sample
    xfer(0, 0, 12, 16'h0, 16'h0ABC, 1'b0, 1'b0, "R4");
    // R7 falling edges, mixed phases
    wr(4'h4, 16'h0003);
    xfer(0, 4, 4, 16'h9000, 16'h0006, 1'b1, 1'b1, "R7");
    wr(4'h4, 16'h0000);
    // R8 / R9 serial period
    wr(4'h4, 16'h0200);
    wr(4'h8, 16'h0003);
    xfer(1, 2, 0, 16'h8000, 16'h0, 1'b0, 1'b0, "R8");
    chk(t_rise.size() >= 2 && t_rise[1] - t_rise[0] == 16, "R8 period div4 presc4",
        t_rise.size() >= 2 ? t_rise[1] - t_rise[0] : -1, 16);
    wr(4'h8, 16'h0005);
    xfer(0, 2, 0, 16'h4000, 16'h0, 1'b0, 1'b0, "R9");
    chk(t_rise.size() >= 2 && t_rise[1] - t_rise[0] == 14, "R9 period presc7",
        t_rise.size() >= 2 ? t_rise[1] - t_rise[0] : -1, 14);
    wr(4'h6, 16'h0404);
    wr(4'h8, 16'h0007);
    xfer(3, 2, 0, 16'hC000, 16'h0, 1'b0, 1'b0, "R9");
    chk(t_rise.size() >= 2 && t_rise[1] - t_rise[0] == 80, "R9 period presc10 div8",
        t_rise.size() >= 2 ? t_rise[1] - t_rise[0] : -1, 80);
    wr(4'h8, 16'h0001);
    // R10 enable low freezes a transfer
    arm(2, 0, 16'h0, 1'b0);
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'hC000);
    wr(4'h2, 16'((1 << 13) | (2 << 5)));
    repeat (40) @(posedge clk);
    rd(4'h2, 1'b0, v);
    chk(v[14] == 1'b1, "R10 busy held", int'(v[14]), 1);
    chk(rise_n == 0, "R10 no edges", rise_n, 0);
    wr(4'h8, 16'h0001);
    wait_idle("R10 resumes");
    chk(rise_n == 2, "R10 edges after enable", rise_n, 2);
    // R10 / R6 select change waits for the enable
    wr(4'h8, 16'h0000);
    pend = 1'b1;
    wr(4'h2, 16'h0000);
    repeat (10) @(posedge clk);
    rd(4'h2, 1'b0, v);
    chk(v[14] == 1'b1, "R6 busy while pending", int'(v[14]), 1);
    chk(cs_o[0] == 1'b0, "R6 select unchanged", int'(cs_o[0]), 0);
    wr(4'h8, 16'h0001);
    wait_idle("R6 release done");
    m_act[0] = 1'b0;
    pend = 1'b0;
    chk(cs_o[0] == 1'b1, "R6 released", int'(cs_o[0]), 1);
    // R11 zero counts
    arm(0, 0, 16'h0, 1'b0);
    wr(4'h2, 16'h2000);
    rd(4'h2, 1'b0, v);
    chk(v[14] == 1'b0, "R11 done at once", int'(v[14]), 0);
    chk(rise_n == 0, "R11 no edges", rise_n, 0);
    // R12 clamp
    xfer(0, 31, 0, 16'hC3A5, 16'h0, 1'b0, 1'b0, "R12");
    xfer(0, 0, 20, 16'h0, 16'h5A3C, 1'b0, 1'b0, "R12");
    finish_up();
  end
endmodule